// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Pipeline

This block resolves data hazards in a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). A combinational hazard controller looks at the register specifiers and control bits in the decode, execute, memory and writeback pipeline registers. It produces three things: a bypass select for each ALU operand, an interlock that holds the fetch point and the decode register, and a bubble that clears the control bits entering execute. To make the controller observable, it sits inside a small pipeline shell. The shell has a register file, a behavioural ALU and a modelled data read.

Instructions enter through a valid/ready stream. An instruction is taken on a rising clock edge when `in_valid` and `in_ready` are both high. While the interlock is active, `in_ready` is low and the source must hold its instruction. Cycles in which `in_valid` is low put an empty slot into the pipeline. Results leave through a writeback port, one beat per register-writing instruction, in program order. The writeback port has no back-pressure.

Top module: `fwd_hazard_pipe`

## Requirements
- R1: When the instruction in execute reads a source register that the instruction one position ahead writes, that operand's select is 2'b10 and the operand takes the execute/memory result.
- R2: When the producer is two positions ahead, the select is 2'b01 and the value comes from the memory/writeback register. When the producer is three positions ahead, the register file returns the value written in that same cycle and the select is 2'b00.
- R3: A load in execute whose destination is read by the instruction in decode raises `load_stall` for exactly one cycle. `in_ready` is low during that cycle.
- R4: During the interlock cycle, the slot entering execute is a no-op: it writes no register and produces no writeback beat.
- R5: During the interlock, the decode register and the instruction offered at the input are held. Every accepted instruction completes exactly once, in order.
- R6: The loaded value is the address XOR the parameter LOAD_KEY, where the address is rs1 plus the immediate. After the bubble, the loaded value reaches the dependent instruction through select 2'b01.
- R7: When both the execute/memory and memory/writeback registers write a source register, the execute/memory value wins (select 2'b10).
- R8: A destination of register 0 never causes bypassing, interlock or a writeback beat. Register 0 always reads as zero.
- R9: An operand that the instruction in execute does not read has select 2'b00. NOP reads neither operand, ADDI and LOAD read only rs1, and ADD, SUB and XOR read both.
- R10: `wb_valid` pulses once for each accepted instruction that writes a nonzero register, in program order, with `wb_rd` and the result on `wb_data`.
- R11: The opcode encoding is 0 NOP, 1 ADD, 2 SUB, 3 XOR, 4 ADDI (rs1 + imm), 5 LOAD. The 16-bit immediate is sign-extended.
- R12: After reset the pipeline is empty, all registers hold zero, `in_ready` is high, `load_stall` and `wb_valid` are low, and both selects are 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction accepted this cycle if valid |
| in_op | input | 3 | Opcode |
| in_rd | input | 5 | Destination register |
| in_rs1 | input | 5 | First source register |
| in_rs2 | input | 5 | Second source register |
| in_imm | input | 16 | Immediate, sign-extended |
| fwd_a_sel | output | 2 | Operand A select for the instruction in execute |
| fwd_b_sel | output | 2 | Operand B select for the instruction in execute |
| load_stall | output | 1 | Load-use interlock active (bubble inserted) |
| wb_valid | output | 1 | Writeback beat |
| wb_rd | output | 5 | Register written |
| wb_data | output | 32 | Value written |

## Verification
A wrong select or a missed interlock produces a wrong value, and that value shows up on `wb_data` two cycles after the faulty execute cycle. Every dependent instruction after it then inherits the error. A comparison on every cycle of the selects and of `load_stall` catches a fault in the controller in the same cycle that it occurs. A lost or duplicated instruction shifts the writeback stream out of alignment with program order. Replaying each register through ADDI at the end exposes any corruption that stayed silent.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  parameter int XLEN  = 32;
  parameter int NREG  = 32;
  parameter int IMM_W = 16;
  localparam int RIDX = $clog2(NREG);

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_ADD  = 3'd1,
    OP_SUB  = 3'd2,
    OP_XOR  = 3'd3,
    OP_ADDI = 3'd4,
    OP_LOAD = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_MWB = 2'b01,
    SEL_EXM = 2'b10
  } sel_e;

  typedef struct packed {
    logic             valid;
    op_e              op;
    logic [RIDX-1:0]  rd;
    logic [RIDX-1:0]  rs1;
    logic [RIDX-1:0]  rs2;
    logic [IMM_W-1:0] imm;
  } ifid_t;

  typedef struct packed {
    op_e             op;
    logic            regwrite;
    logic            is_load;
    logic            use_a;
    logic            use_b;
    logic [RIDX-1:0] rd;
    logic [RIDX-1:0] rs1;
    logic [RIDX-1:0] rs2;
    logic [XLEN-1:0] a_val;
    logic [XLEN-1:0] b_val;
    logic [XLEN-1:0] imm;
  } idex_t;

  typedef struct packed {
    logic            regwrite;
    logic            is_load;
    logic [RIDX-1:0] rd;
    logic [XLEN-1:0] result;
  } exm_t;

  typedef struct packed {
    logic            regwrite;
    logic [RIDX-1:0] rd;
    logic [XLEN-1:0] wdata;
  } mwb_t;

  function automatic logic reads_a(op_e op);
    return op inside {OP_ADD, OP_SUB, OP_XOR, OP_ADDI, OP_LOAD};
  endfunction

  function automatic logic reads_b(op_e op);
    return op inside {OP_ADD, OP_SUB, OP_XOR};
  endfunction

  function automatic logic writes_rd(op_e op);
    return op != OP_NOP;
  endfunction
endpackage

// File: rtl/fwd_regfile.sv
module fwd_regfile
  import fwd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [RIDX-1:0]      waddr,
  input  logic [XLEN-1:0]      wdata,
  input  logic [2*RIDX-1:0]    raddr,
  output logic [2*XLEN-1:0]    rdata
);
  logic [XLEN-1:0] mem [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (we && waddr != '0) begin
      mem[waddr] <= wdata;
    end
  end

  // Write-before-read: a same-cycle write is visible to the reader.
  for (genvar p = 0; p < 2; p++) begin : g_rd
    logic [RIDX-1:0] ra;
    assign ra = raddr[p*RIDX +: RIDX];
    always_comb begin
      if (ra == '0)                 rdata[p*XLEN +: XLEN] = '0;
      else if (we && waddr == ra)   rdata[p*XLEN +: XLEN] = wdata;
      else                          rdata[p*XLEN +: XLEN] = mem[ra];
    end
  end
endmodule

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
  import fwd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            use_src,
  input  logic [RIDX-1:0] src,
  input  logic            exm_wr,
  input  logic            exm_load,
  input  logic [RIDX-1:0] exm_rd,
  input  logic            mwb_wr,
  input  logic [RIDX-1:0] mwb_rd,
  output sel_e            sel
);
  logic hit_exm, hit_mwb;
  assign hit_exm = use_src && exm_wr && exm_rd != '0 && exm_rd == src;
  assign hit_mwb = use_src && mwb_wr && mwb_rd != '0 && mwb_rd == src;

  always_comb begin
    if (hit_exm)      sel = SEL_EXM;   // younger producer wins
    else if (hit_mwb) sel = SEL_MWB;
    else              sel = SEL_RF;
  end

  // The interlock must keep a load's address from ever being bypassed as data.
  AST_NO_LOAD_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    sel == SEL_EXM |-> !exm_load); // R3
endmodule

// File: rtl/fwd_load_use.sv
module fwd_load_use
  import fwd_pkg::*;
(
  input  logic            id_valid,
  input  op_e             id_op,
  input  logic [RIDX-1:0] id_rs1,
  input  logic [RIDX-1:0] id_rs2,
  input  logic            ex_load,
  input  logic            ex_wr,
  input  logic [RIDX-1:0] ex_rd,
  output logic            stall
);
  logic dep_a, dep_b;
  assign dep_a = reads_a(id_op) && id_rs1 == ex_rd;
  assign dep_b = reads_b(id_op) && id_rs2 == ex_rd;
  assign stall = id_valid && ex_load && ex_wr && ex_rd != '0 && (dep_a || dep_b);
endmodule

// File: rtl/fwd_hazard_pipe.sv
module fwd_hazard_pipe
  import fwd_pkg::*;
#(
  parameter logic [31:0] LOAD_KEY = 32'h5A5A_0F0F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_op,
  input  logic [RIDX-1:0]  in_rd,
  input  logic [RIDX-1:0]  in_rs1,
  input  logic [RIDX-1:0]  in_rs2,
  input  logic [IMM_W-1:0] in_imm,
  output logic [1:0]       fwd_a_sel,
  output logic [1:0]       fwd_b_sel,
  output logic             load_stall,
  output logic             wb_valid,
  output logic [RIDX-1:0]  wb_rd,
  output logic [XLEN-1:0]  wb_data
);
  ifid_t ifid;
  idex_t idex;
  exm_t  exm;
  mwb_t  mwb;

  logic stall;
  logic bubble;

  // ---------------- hazard detection ----------------
  fwd_load_use u_lu (
    .id_valid (ifid.valid),
    .id_op    (ifid.op),
    .id_rs1   (ifid.rs1),
    .id_rs2   (ifid.rs2),
    .ex_load  (idex.is_load),
    .ex_wr    (idex.regwrite),
    .ex_rd    (idex.rd),
    .stall    (stall)
  );
  assign bubble     = stall;
  assign in_ready   = !stall;
  assign load_stall = stall;

  // ---------------- fetch -> decode register ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ifid <= '0;
    end else if (!stall) begin
      ifid.valid <= in_valid;
      ifid.op    <= op_e'(in_op);
      ifid.rd    <= in_rd;
      ifid.rs1   <= in_rs1;
      ifid.rs2   <= in_rs2;
      ifid.imm   <= in_imm;
    end
  end

  // ---------------- decode ----------------
  logic [2*XLEN-1:0] rf_rdata;
  fwd_regfile u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mwb.regwrite),
    .waddr (mwb.rd),
    .wdata (mwb.wdata),
    .raddr ({ifid.rs2, ifid.rs1}),
    .rdata (rf_rdata)
  );

  idex_t idex_nxt;
  always_comb begin
    idex_nxt = '0;
    if (ifid.valid && !bubble) begin
      idex_nxt.op       = ifid.op;
      idex_nxt.regwrite = writes_rd(ifid.op) && ifid.rd != '0;
      idex_nxt.is_load  = ifid.op == OP_LOAD;
      idex_nxt.use_a    = reads_a(ifid.op);
      idex_nxt.use_b    = reads_b(ifid.op);
      idex_nxt.rd       = ifid.rd;
      idex_nxt.rs1      = ifid.rs1;
      idex_nxt.rs2      = ifid.rs2;
      idex_nxt.a_val    = rf_rdata[0 +: XLEN];
      idex_nxt.b_val    = rf_rdata[XLEN +: XLEN];
      idex_nxt.imm      = {{(XLEN-IMM_W){ifid.imm[IMM_W-1]}}, ifid.imm};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idex <= '0;
    else        idex <= idex_nxt;
  end

  // ---------------- execute: operand bypass ----------------
  sel_e              sel [2];
  logic [XLEN-1:0]   opnd [2];
  logic [1:0]        use_v;
  logic [2*RIDX-1:0] src_v;
  logic [2*XLEN-1:0] rfv_v;

  assign use_v = {idex.use_b, idex.use_a};
  assign src_v = {idex.rs2, idex.rs1};
  assign rfv_v = {idex.b_val, idex.a_val};

  for (genvar k = 0; k < 2; k++) begin : g_opnd
    fwd_operand_sel u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .use_src  (use_v[k]),
      .src      (src_v[k*RIDX +: RIDX]),
      .exm_wr   (exm.regwrite),
      .exm_load (exm.is_load),
      .exm_rd   (exm.rd),
      .mwb_wr   (mwb.regwrite),
      .mwb_rd   (mwb.rd),
      .sel      (sel[k])
    );
    always_comb begin
      unique case (sel[k])
        SEL_EXM: opnd[k] = exm.result;
        SEL_MWB: opnd[k] = mwb.wdata;
        default: opnd[k] = rfv_v[k*XLEN +: XLEN];
      endcase
    end
  end

  assign fwd_a_sel = sel[0];
  assign fwd_b_sel = sel[1];

  logic [XLEN-1:0] alu_out;
  always_comb begin
    unique case (idex.op)
      OP_ADD:           alu_out = opnd[0] + opnd[1];
      OP_SUB:           alu_out = opnd[0] - opnd[1];
      OP_XOR:           alu_out = opnd[0] ^ opnd[1];
      OP_ADDI, OP_LOAD: alu_out = opnd[0] + idex.imm;
      default:          alu_out = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exm <= '0;
    end else begin
      exm.regwrite <= idex.regwrite;
      exm.is_load  <= idex.is_load;
      exm.rd       <= idex.rd;
      exm.result   <= alu_out;
    end
  end

  // ---------------- memory: modelled data read ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mwb <= '0;
    end else begin
      mwb.regwrite <= exm.regwrite;
      mwb.rd       <= exm.rd;
      mwb.wdata    <= exm.is_load ? (exm.result ^ LOAD_KEY[XLEN-1:0]) : exm.result;
    end
  end

  // ---------------- writeback ----------------
  assign wb_valid = mwb.regwrite;
  assign wb_rd    = mwb.rd;
  assign wb_data  = mwb.wdata;

  // ---------------- assertions ----------------
  AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall); // R3
  AST_BUBBLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !idex.regwrite && !idex.is_load); // R4
  AST_IFID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(ifid)); // R5
  AST_WB_NOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> wb_rd != '0); // R8
endmodule

// File: tb/fwd_hazard_pipe_tb.sv
module fwd_hazard_pipe_tb;
  import fwd_pkg::*;

  localparam logic [31:0] KEY = 32'h5A5A_0F0F;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [2:0]  in_op = 0;
  logic [4:0]  in_rd = 0, in_rs1 = 0, in_rs2 = 0;
  logic [15:0] in_imm = 0;
  logic [1:0]  fwd_a_sel, fwd_b_sel;
  logic        load_stall, wb_valid;
  logic [4:0]  wb_rd;
  logic [31:0] wb_data;

  always #5 clk = ~clk;

  fwd_hazard_pipe #(.LOAD_KEY(KEY)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_rd(in_rd), .in_rs1(in_rs1), .in_rs2(in_rs2), .in_imm(in_imm),
    .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel), .load_stall(load_stall),
    .wb_valid(wb_valid), .wb_rd(wb_rd), .wb_data(wb_data)
  );

  typedef struct { bit v; int op; int rd; int rs1; int rs2; } slot_t;

  slot_t s_id, s_ex, s_mem, s_wb;
  logic [31:0] regs [32];
  logic [31:0] q_data[$];
  int          q_rd[$];
  int checks = 0, fails = 0, exp_bubbles = 0, seen_bubbles = 0, cyc = 0;

  function automatic bit m_ra(int op); return op >= 1 && op <= 5; endfunction
  function automatic bit m_rb(int op); return op >= 1 && op <= 3; endfunction
  function automatic bit m_wr(slot_t s); return s.v && s.op != 0 && s.rd != 0; endfunction

  function automatic bit m_stall();
    return s_id.v && s_ex.v && s_ex.op == 5 && s_ex.rd != 0 &&
           ((m_ra(s_id.op) && s_id.rs1 == s_ex.rd) || (m_rb(s_id.op) && s_id.rs2 == s_ex.rd));
  endfunction

  function automatic logic [1:0] m_sel(bit use_it, int src);
    if (!use_it || src == 0) return 2'b00;
    if (m_wr(s_mem) && s_mem.rd == src) return 2'b10; // R7 priority
    if (m_wr(s_wb) && s_wb.rd == src) return 2'b01;
    return 2'b00;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  task automatic check_outputs();
    bit st;
    st = m_stall();
    chk("R3 load_stall", {31'b0, load_stall}, {31'b0, st});
    chk("R5 in_ready", {31'b0, in_ready}, {31'b0, !st});
    chk("R1/R2/R9 fwd_a_sel", {30'b0, fwd_a_sel}, {30'b0, m_sel(s_ex.v && m_ra(s_ex.op), s_ex.rs1)});
    chk("R1/R2/R9 fwd_b_sel", {30'b0, fwd_b_sel}, {30'b0, m_sel(s_ex.v && m_rb(s_ex.op), s_ex.rs2)});
    if (load_stall) seen_bubbles++;
    if (m_wr(s_wb)) begin
      chk("R10 wb_valid", {31'b0, wb_valid}, 32'd1);
      if (q_rd.size() > 0) begin
        chk("R10 wb_rd", {27'b0, wb_rd}, q_rd.pop_front());
        chk("R6/R10 wb_data", wb_data, q_data.pop_front());
      end else chk("R5 writeback queue empty", 32'd1, 32'd0);
    end else begin
      chk("R4/R8 wb_valid idle", {31'b0, wb_valid}, 32'd0);
    end
  endtask

  // Behavioural execution of one accepted instruction (R11 encoding).
  task automatic exec(int op, int rd, int rs1, int rs2, logic [15:0] imm);
    logic [31:0] a, b, ix, r;
    a = regs[rs1]; b = regs[rs2];
    ix = {{16{imm[15]}}, imm};
    case (op)
      1: r = a + b;
      2: r = a - b;
      3: r = a ^ b;
      4: r = a + ix;
      5: r = (a + ix) ^ KEY;
      default: r = 0;
    endcase
    if (op != 0 && rd != 0) begin
      regs[rd] = r;
      q_rd.push_back(rd);
      q_data.push_back(r);
    end
  endtask

  task automatic step(bit v, int op, int rd, int rs1, int rs2, logic [15:0] imm);
    bit st, acc;
    slot_t nw;
    in_valid = v; in_op = op[2:0]; in_rd = rd[4:0];
    in_rs1 = rs1[4:0]; in_rs2 = rs2[4:0]; in_imm = imm;
    st = m_stall();
    if (st) exp_bubbles++;
    acc = v && !st;
    if (acc) exec(op, rd, rs1, rs2, imm);
    nw.v = acc; nw.op = op; nw.rd = rd; nw.rs1 = rs1; nw.rs2 = rs2;
    @(posedge clk);
    cyc++;
    s_wb = s_mem;
    s_mem = s_ex;
    if (st) s_ex = '{0, 0, 0, 0, 0};
    else begin
      s_ex = s_id;
      s_id = nw;
    end
    @(negedge clk);
    check_outputs();
  endtask

  // Offer one instruction until accepted.
  task automatic issue(int op, int rd, int rs1, int rs2, logic [15:0] imm);
    bit done = 0;
    while (!done) begin
      done = !m_stall();
      step(1, op, rd, rs1, rs2, imm);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 16'h0);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) regs[i] = 0;
    s_id = '{0,0,0,0,0}; s_ex = s_id; s_mem = s_id; s_wb = s_id;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk("R12 in_ready", {31'b0, in_ready}, 32'd1);
    chk("R12 load_stall", {31'b0, load_stall}, 32'd0);
    chk("R12 wb_valid", {31'b0, wb_valid}, 32'd0);
    chk("R12 selects", {28'b0, fwd_a_sel, fwd_b_sel}, 32'd0);

    // R1: back-to-back dependency
    issue(4, 1, 0, 0, 16'd7);
    issue(1, 2, 1, 1, 16'd0);
    // R2: distance two and three
    issue(4, 3, 0, 0, 16'hFFF0);
    issue(0, 0, 0, 0, 16'd0);
    issue(2, 4, 3, 1, 16'd0);
    issue(4, 5, 0, 0, 16'd100);
    issue(0, 0, 0, 0, 16'd0);
    issue(0, 0, 0, 0, 16'd0);
    issue(3, 6, 5, 5, 16'd0);
    // R7: both stages write the same register
    issue(4, 7, 0, 0, 16'd1);
    issue(4, 7, 0, 0, 16'd2);
    issue(1, 8, 7, 7, 16'd0);
    // R3/R6: load-use, both operands
    issue(5, 9, 1, 0, 16'd4);
    issue(1, 10, 9, 9, 16'd0);
    issue(5, 11, 2, 0, 16'd0);
    issue(2, 12, 3, 11, 16'd0);
    // R8: register 0 producers, load to r0 causes no stall
    issue(4, 0, 1, 0, 16'd9);
    issue(1, 13, 0, 0, 16'd0);
    issue(5, 0, 1, 0, 16'd0);
    issue(1, 14, 0, 1, 16'd0);
    // R9: ADDI does not read rs2 even if it names a producer
    issue(4, 15, 0, 14, 16'd3);
    idle(6);

    // Randomized dependent sequences over a small register window
    for (int n = 0; n < 3000; n++) begin
      int op, rd, r1, r2;
      logic [15:0] im;
      op = $urandom_range(0, 5);
      rd = $urandom_range(0, 7);
      r1 = $urandom_range(0, 7);
      r2 = $urandom_range(0, 7);
      im = 16'($urandom);
      if ($urandom_range(0, 9) < 2) idle(1);
      issue(op, rd, r1, r2, im);
    end
    idle(6);

    // Final contents replayed through ADDI rX, rX, 0 (R10)
    for (int r = 1; r < 16; r++) issue(4, r, r, 0, 16'd0);
    idle(6);

    chk("R3 bubble count", seen_bubbles, exp_bubbles);
    chk("R5 writeback queue drained", q_rd.size(), 32'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule